// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters from a processor into asynchronous serial frames on a single output line. A character written through the write strobe lands in a holding register. When the line is free, the character moves into a separate shift register. This frees the holding register for the next character while the current frame is still going out. Consecutive characters therefore leave with no gap between them.

Each frame starts with a low start bit. The data bits follow, least significant first. In the nine-bit mode a computed parity bit comes next, and a high stop bit closes the frame. Every bit lasts sixteen oversample ticks. A tick comes once every `divisor` clocks, so the same divisor value can also drive a matching receiver. Two flags report progress: one says the holding register can take a byte, and the other says the line has gone quiet. A break request holds the line low for whole bit times. It is followed by one high bit time before any queued character starts.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, `txLine` is 1, `drEmpty` is 1 and `txComplete` is 1.
- R2: While `txEnable` is 0, a write strobe is ignored: `drEmpty` stays 1 and no frame or break starts.
- R3: A write accepted at a clock edge makes `drEmpty` 0 after that edge. If the transmitter is idle, the next edge moves the byte into the shift register. After that edge `drEmpty` is 1 again, `txComplete` is 0, and the start bit is on the line.
- R4: A frame is a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. Each bit lasts 16 ticks, and a tick occurs every `divisor` clocks. A `divisor` of 0 behaves as 1.
- R5: When `nineBit` is 1, a parity bit follows bit 7 and precedes the stop bit. With `parityOdd` = 1 the count of ones in the data plus parity is odd; with 0 it is even. For example, data 0x41 with odd parity sends a parity bit of 1.
- R6: A write during a frame leaves that frame unchanged. A byte queued before a stop bit ends starts its start bit on the clock edge that ends the stop bit, with no idle gap.
- R7: A queued byte keeps `drEmpty` at 0 until the edge where it moves into the shift register.
- R8: `txComplete` is 0 from the first start bit through the end of the last stop bit. It becomes 1 on the edge that ends a stop bit when no byte is queued.
- R9: A break request with `txEnable` at 1 takes effect at idle or at the end of a frame. The line then stays 0 for whole bit times: for at least 10 bit times (11 in nine-bit mode), and until the first bit boundary at which `breakReq` is seen as 0.
- R10: After a break, the line is 1 for exactly one bit time before a queued frame starts.
- R11: A second write while a byte is already queued replaces the queued byte. The character sent is the one written last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txEnable | input | 1 | Enables writes, new frames and breaks |
| breakReq | input | 1 | Hold the line low while set |
| nineBit | input | 1 | Add a parity bit after the data |
| parityOdd | input | 1 | 1 selects odd parity, 0 even |
| divisor | input | DIV_W | Clocks per oversample tick |
| wrStrobe | input | 1 | One-cycle write of `wrData` |
| wrData | input | DATA_W | Character to send |
| txLine | output | 1 | Serial output, idles at 1 |
| drEmpty | output | 1 | Holding register can take a byte |
| txComplete | output | 1 | No frame or break in progress |

## Verification
Single isolated frames, sampled in the middle of each bit, show that the framing, the bit order and the bit length are correct. Runs with divisors of 0, 1, 2 and 3 and random data in both frame modes separate a wrong tick rate from a wrong bit order. Writes made during a frame, including an overwrite of the queued byte, show whether the holding and shift registers are truly independent and whether frames follow each other with no gap. Breaks released early and released late, in both frame modes, measure the exact low time and the one-bit high gap that follows. This separates the minimum-length rule from the release-at-boundary rule.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [1:0] {LINE_MARK, LINE_SHIFT, LINE_SPACE} lineSel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_BREAK, ST_MARK} txState_e;
  typedef struct packed {
    logic     loadShift;
    logic     shiftBit;
    lineSel_e lineSel;
  } txStrobe_t;
endpackage

// File: rtl/tx_datapath.sv
module tx_datapath
  import tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              nineBit,
  input  logic              parityOdd,
  input  txStrobe_t         strobe,
  output logic              drFull,
  output logic              txLine
);
  localparam int SHIFT_W = DATA_W + 3;

  logic [DATA_W-1:0]  drReg;
  logic [SHIFT_W-1:0] shiftReg;
  logic               wrAcc;
  logic               parBit;

  assign wrAcc  = wrStrobe && txEnable;
  assign parBit = nineBit ? ((^drReg) ^ parityOdd) : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drReg  <= '0;
      drFull <= 1'b0;
    end else if (wrAcc) begin
      drReg  <= wrData;
      drFull <= 1'b1;
    end else if (strobe.loadShift) begin
      drFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (strobe.loadShift) begin
      shiftReg <= {1'b1, parBit, drReg, 1'b0};
    end else if (strobe.shiftBit) begin
      shiftReg <= {1'b1, shiftReg[SHIFT_W-1:1]};
    end
  end

  always_comb begin
    case (strobe.lineSel)
      LINE_SHIFT: txLine = shiftReg[0];
      LINE_SPACE: txLine = 1'b0;
      default:    txLine = 1'b1;
    endcase
  end

  assert_write_captures_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrAcc |=> (drFull && drReg == $past(wrData)));

  assert_disabled_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnable && !drFull) |=> !drFull);

  assert_load_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadShift && !wrAcc) |=> !drFull);

  assert_shift_fill_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftBit && !strobe.loadShift) |=>
      shiftReg == {1'b1, $past(shiftReg[SHIFT_W-1:1])});
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
  import tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 12,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             breakReq,
  input  logic             nineBit,
  input  logic [DIV_W-1:0] divisor,
  input  logic             drFull,
  output txStrobe_t        strobe,
  output logic             txComplete
);
  localparam int SUB_W   = $clog2(OVERSAMPLE);
  localparam int MAXBITS = DATA_W + 3;
  localparam int BIT_W   = $clog2(MAXBITS + 1);
  localparam logic [BIT_W-1:0] LAST_PLAIN  = BIT_W'(DATA_W + 1);
  localparam logic [BIT_W-1:0] LAST_PARITY = BIT_W'(DATA_W + 2);
  localparam logic [SUB_W-1:0] SUB_LAST    = SUB_W'(OVERSAMPLE - 1);

  txState_e         state, nextState;
  logic [DIV_W-1:0] preCnt, divEff;
  logic [SUB_W-1:0] subCnt;
  logic [BIT_W-1:0] bitIdx, lastIdx;
  logic             tick, bitEnd, atLast, boundary, loadShift, restart;

  assign divEff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick   = (preCnt >= divEff - DIV_W'(1));
  assign bitEnd = (state != ST_IDLE) && tick && (subCnt == SUB_LAST);
  assign atLast = (bitIdx >= lastIdx);

  always_comb begin
    nextState = state;
    boundary  = 1'b0;
    loadShift = 1'b0;
    case (state)
      ST_IDLE:  boundary = 1'b1;
      ST_SEND:  boundary = bitEnd && atLast;
      ST_MARK:  boundary = bitEnd;
      ST_BREAK: if (bitEnd && atLast && !breakReq) nextState = ST_MARK;
      default:  nextState = ST_IDLE;
    endcase
    if (boundary) begin
      if (txEnable && breakReq) begin
        nextState = ST_BREAK;
      end else if (txEnable && drFull) begin
        nextState = ST_SEND;
        loadShift = 1'b1;
      end else begin
        nextState = ST_IDLE;
      end
    end
  end

  assign restart = (nextState != state) || loadShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      preCnt  <= '0;
      subCnt  <= '0;
      bitIdx  <= '0;
      lastIdx <= LAST_PLAIN;
    end else begin
      state <= nextState;
      if (restart) begin
        preCnt  <= '0;
        subCnt  <= '0;
        bitIdx  <= '0;
        lastIdx <= nineBit ? LAST_PARITY : LAST_PLAIN;
      end else if (state != ST_IDLE) begin
        if (tick) begin
          preCnt <= '0;
          subCnt <= (subCnt == SUB_LAST) ? '0 : subCnt + SUB_W'(1);
          if (bitEnd && !atLast) bitIdx <= bitIdx + BIT_W'(1);
        end else begin
          preCnt <= preCnt + DIV_W'(1);
        end
      end
    end
  end

  always_comb begin
    strobe.loadShift = loadShift;
    strobe.shiftBit  = (state == ST_SEND) && bitEnd && !atLast;
    case (state)
      ST_SEND:  strobe.lineSel = LINE_SHIFT;
      ST_BREAK: strobe.lineSel = LINE_SPACE;
      default:  strobe.lineSel = LINE_MARK;
    endcase
  end

  assign txComplete = (state == ST_IDLE);

  assert_break_min_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_BREAK && state == ST_MARK) |->
      ($past(bitIdx) >= $past(lastIdx) && !$past(breakReq)));

  assert_frame_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && !bitEnd) |=> state == ST_SEND);
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 12,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              breakReq,
  input  logic              nineBit,
  input  logic              parityOdd,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              txLine,
  output logic              drEmpty,
  output logic              txComplete
);
  txStrobe_t strobe;
  logic      drFull;

  tx_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .OVERSAMPLE(OVERSAMPLE)) i_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .breakReq(breakReq),
    .nineBit(nineBit), .divisor(divisor), .drFull(drFull),
    .strobe(strobe), .txComplete(txComplete)
  );

  tx_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .wrStrobe(wrStrobe),
    .wrData(wrData), .nineBit(nineBit), .parityOdd(parityOdd),
    .strobe(strobe), .drFull(drFull), .txLine(txLine)
  );

  assign drEmpty = !drFull;

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    txComplete |-> txLine);
endmodule

// File: tb/test_async_frame_tx.sv
module test_async_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 12;
  localparam int OS     = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic txEnable = 1'b0, breakReq = 1'b0, nineBit = 1'b0, parityOdd = 1'b0;
  logic [DIV_W-1:0] divisor = DIV_W'(1);
  logic wrStrobe = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic txLine, drEmpty, txComplete;
  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_frame_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W), .OVERSAMPLE(OS)) i_async_frame_tx (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .breakReq(breakReq),
    .nineBit(nineBit), .parityOdd(parityOdd), .divisor(divisor),
    .wrStrobe(wrStrobe), .wrData(wrData), .txLine(txLine),
    .drEmpty(drEmpty), .txComplete(txComplete)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] expFrame(logic [7:0] d, bit nine, bit odd);
    return {1'b1, nine ? ((^d) ^ odd) : 1'b1, d, 1'b0};
  endfunction

  function automatic int frameLen(bit nine);
    return nine ? 11 : 10;
  endfunction

  function automatic int breakLen(int hold, bit nine);
    int bits = (hold + OS - 1) / OS;
    return OS * ((bits > frameLen(nine)) ? bits : frameLen(nine));
  endfunction

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk);
    wrData = d;
    wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  // mode 0: find start edge, 1: advance one bit from previous stop middle,
  // 2: already at the middle of the start bit. Ends at the stop-bit middle.
  task automatic recvFrame(input int mode, input int bt, input logic [7:0] d,
                           input bit nine, input bit odd, input string req);
    logic [10:0] got = '1;
    logic [10:0] exp = expFrame(d, nine, odd);
    int guard = 0;
    if (mode == 0) begin
      while (txLine !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
      repeat (bt/2) @(negedge clk);
    end else if (mode == 1) begin
      repeat (bt) @(negedge clk);
    end
    for (int i = 0; i < frameLen(nine); i++) begin
      if (i > 0) repeat (bt) @(negedge clk);
      got[i] = txLine;
    end
    check(got == exp, req, int'(got), int'(exp));
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (!txComplete && guard < 5000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic doBreak(input int hold, input bit nine, input bit queue,
                         input logic [7:0] d, input string req);
    int lowCnt = 0, highCnt = 0;
    @(negedge clk);
    nineBit = nine;
    breakReq = 1'b1;
    @(negedge clk);
    while (txLine == 1'b0 && lowCnt < 3000) begin
      if (lowCnt == hold - 1) breakReq = 1'b0;
      if (queue && lowCnt == 20) begin wrData = d; wrStrobe = 1'b1; end
      else wrStrobe = 1'b0;
      lowCnt++;
      @(negedge clk);
    end
    breakReq = 1'b0;
    check(lowCnt == breakLen(hold, nine), {req, " R9 break low length"}, lowCnt, breakLen(hold, nine));
    check(txComplete == 1'b0, "R9 complete low after break", int'(txComplete), 0);
    while (txLine == 1'b1 && highCnt < 100) begin highCnt++; @(negedge clk); end
    if (queue) begin
      check(highCnt == OS, "R10 one mark bit before queued frame", highCnt, OS);
      recvFrame(0, OS, d, nine, 1'b0, "R10 queued frame after break");
    end
    waitIdle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int lows;
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine == 1'b1, "R1 reset line", int'(txLine), 1);
    check(drEmpty == 1'b1, "R1 reset empty", int'(drEmpty), 1);
    check(txComplete == 1'b1, "R1 reset complete", int'(txComplete), 1);

    // R2: disabled writes are ignored
    writeByte(8'h5A);
    check(drEmpty == 1'b1, "R2 disabled write empty", int'(drEmpty), 1);
    lows = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!txLine) lows++; end
    check(lows == 0 && txComplete, "R2 no frame while disabled", lows, 0);

    // R3 / R4 / R8: single frame timing
    txEnable = 1'b1;
    writeByte(8'h41);
    check(!drEmpty && txComplete && txLine, "R3 queued after write",
          {drEmpty, txComplete, txLine}, 3'b011);
    @(negedge clk);
    check(drEmpty && !txComplete && !txLine, "R3 transferred next edge",
          {drEmpty, txComplete, txLine}, 3'b100);
    recvFrame(0, OS, 8'h41, 1'b0, 1'b0, "R4 8-bit frame 0x41");
    repeat (7) @(negedge clk);
    check(txComplete == 1'b0, "R8 complete low at end of stop", int'(txComplete), 0);
    @(negedge clk);
    check(txComplete && txLine, "R8 complete after stop", {txComplete, txLine}, 2'b11);

    // R5: parity
    nineBit = 1'b1; parityOdd = 1'b1;
    writeByte(8'h41);
    recvFrame(0, OS, 8'h41, 1'b1, 1'b1, "R5 odd parity 0x41 (parity 1)");
    waitIdle();
    parityOdd = 1'b0;
    writeByte(8'h41);
    recvFrame(0, OS, 8'h41, 1'b1, 1'b0, "R5 even parity 0x41 (parity 0)");
    waitIdle();

    // R6 / R7 / R11: overlapped writes and back-to-back frames
    nineBit = 1'b0;
    writeByte(8'h3C);
    @(negedge clk);
    writeByte(8'h11);
    check(drEmpty == 1'b0, "R7 queued during frame", int'(drEmpty), 0);
    writeByte(8'hC5);
    recvFrame(0, OS, 8'h3C, 1'b0, 1'b0, "R6 first frame undisturbed");
    check(drEmpty == 1'b0, "R7 still queued at stop", int'(drEmpty), 0);
    repeat (OS) @(negedge clk);
    check(!txLine && drEmpty && !txComplete, "R6 next start bit with no gap",
          {txLine, drEmpty, txComplete}, 3'b010);
    recvFrame(2, OS, 8'hC5, 1'b0, 1'b0, "R11 last write sent");
    waitIdle();

    // R4: divisor 0 acts as 1, then other divisors with random data
    divisor = '0;
    writeByte(8'hA7);
    recvFrame(0, OS, 8'hA7, 1'b0, 1'b0, "R4 divisor zero");
    waitIdle();
    for (int k = 0; k < 12; k++) begin
      int dv = 1 + ($urandom % 3);
      bit nb = 1'($urandom % 2);
      bit po = 1'($urandom % 2);
      d = 8'($urandom);
      divisor = DIV_W'(dv);
      nineBit = nb;
      parityOdd = po;
      writeByte(d);
      recvFrame(0, OS * dv, d, nb, po, nb ? "R5 random parity frame" : "R4 random frame");
      waitIdle();
    end
    divisor = DIV_W'(1);
    parityOdd = 1'b0;

    // R9 / R10: breaks
    doBreak(1, 1'b0, 1'b1, 8'h7E, "short");
    doBreak(300, 1'b0, 1'b0, 8'h00, "long");
    doBreak(1, 1'b1, 1'b0, 8'h00, "nine-bit");
    doBreak(160, 1'b0, 1'b1, 8'h81, "exact");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule